// File: doc/BRIEF.md
# Channel and Gain Scan Sequencer

This block replays a short, software-loaded list of scan slots during acquisition. Each slot names an input channel and a gain code. When acquisition is triggered, the sequencer selects slot 0. Each convert strobe then moves it to the next slot. After the last active slot it returns to slot 0, and it keeps cycling until acquisition stops. The selected channel and gain are registered outputs that drive the input multiplexer and the amplifier. The slot index is also an output, so that each converted sample can be tagged with the slot it came from.

Software fills the list through a one-cycle write port while acquisition is off. The same port also sets how many slots are active. When differential inputs are in use, only the lower half of the channel numbers is legal. A write that names a higher channel is refused and raises a configuration error flag.

Top module: `scan_seq_top`

## Requirements
- R1: After reset, chanSel, gainSel and entryIdx are 0, cfgErr is 0 and the active length is 1.
- R2: A slot write (wrEn=1, wrIsLen=0) while acqActive is low stores the pair wrChan/wrGain in slot wrAddr. Each slot keeps its own gain code.
- R3: The first clock edge that samples acqActive high after it was low selects slot 0. From that edge on, chanSel, gainSel and entryIdx show slot 0.
- R4: While acquisition runs, each clock edge that samples convStrobe high moves to the next slot. The outputs show the new slot's channel and gain right after that edge.
- R5: A strobe that arrives on slot length-1 returns the sequencer to slot 0.
- R6: With length 1, every strobe keeps slot 0 selected.
- R7: A length write (wrEn=1, wrIsLen=1) with wrLen from 1 to DEPTH sets the active length. A length write of 0, or of any value above DEPTH, is ignored.
- R8: With diffMode=1, a slot write whose channel is above 7 is refused and sets cfgErr. An accepted slot write clears cfgErr. Length writes leave cfgErr unchanged. With diffMode=0, channels 8 to 15 are accepted.
- R9: Slot and length writes made while acqActive is high have no effect.
- R10: convStrobe has no effect while acqActive is low. The outputs hold their values.
- R11: Every new acquisition starts again from slot 0, wherever the previous one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqActive | input | 1 | High while acquisition is triggered |
| convStrobe | input | 1 | One-cycle convert strobe |
| diffMode | input | 1 | 1 = differential inputs (channels 0 to 7 only) |
| wrEn | input | 1 | Write request |
| wrIsLen | input | 1 | 1 = length write, 0 = slot write |
| wrAddr | input | IDX_W | Slot written |
| wrChan | input | CH_W | Channel for the slot |
| wrGain | input | GAIN_W | Gain code for the slot |
| wrLen | input | LEN_W | Active slot count |
| chanSel | output | CH_W | Multiplexer channel select |
| gainSel | output | GAIN_W | Amplifier gain select |
| entryIdx | output | IDX_W | Index of the current slot |
| cfgErr | output | 1 | Last slot write was refused |

## Verification
Every result of this block is due exactly one edge after the stimulus that causes it. This holds for a start, a strobe, a write and a refused write alike. The bench drives its inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs. Outputs are compared with the model on the next falling edge, so each comparison falls in the cycle right after the edge that should change the output. Directed checks follow the same one-edge pattern: drive, wait for one rising edge, then sample at the falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // strobes issued by the control unit to the datapath for one cycle
  typedef struct packed {
    logic load0;     // acquisition start: select slot 0
    logic advance;   // convert strobe during acquisition
    logic wrEntry;   // accepted slot write
    logic wrLength;  // accepted length write
    logic errSet;    // refused slot write
    logic errClr;    // accepted slot write clears the error
  } seqStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W = 4,
  parameter int DIFF_CHANS = 8,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acqActive,
  input  logic             convStrobe,
  input  logic             diffMode,
  input  logic             wrEn,
  input  logic             wrIsLen,
  input  logic [CH_W-1:0]  wrChan,
  input  logic [LEN_W-1:0] wrLen,
  output seqStrobe_t       strb
);
  localparam logic [CH_W-1:0]  DIFF_LIMIT = CH_W'(DIFF_CHANS - 1);
  localparam logic [LEN_W-1:0] LEN_MAX    = LEN_W'(DEPTH);

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;
  state_t state;

  logic wrOk, lenOk, chanBad;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= acqActive ? ST_SCAN : ST_IDLE;
  end

  always_comb begin
    wrOk    = wrEn && !acqActive;
    lenOk   = (wrLen != '0) && (wrLen <= LEN_MAX);
    chanBad = diffMode && (wrChan > DIFF_LIMIT);
    strb.load0    = acqActive && (state == ST_IDLE);
    strb.advance  = acqActive && (state == ST_SCAN) && convStrobe;
    strb.wrEntry  = wrOk && !wrIsLen && !chanBad;
    strb.errSet   = wrOk && !wrIsLen && chanBad;
    strb.errClr   = wrOk && !wrIsLen && !chanBad;
    strb.wrLength = wrOk && wrIsLen && lenOk;
  end

  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load0 |=> !strb.load0); // R3
  AST_NO_ADV_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.load0 |-> !strb.advance); // R11
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W = 4,
  parameter int GAIN_W = 2,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        ctl,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [GAIN_W-1:0] wrGain,
  input  logic [LEN_W-1:0]  wrLen,
  output logic [CH_W-1:0]   chanSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic [IDX_W-1:0]  entryIdx,
  output logic              cfgErr
);
  logic [CH_W-1:0]   chanQ [DEPTH];
  logic [GAIN_W-1:0] gainQ [DEPTH];
  logic [LEN_W-1:0]  lenReg;
  logic [IDX_W-1:0]  ptr, lastIdx, nextIdx;

  // one register slot per queue entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chanQ[e] <= '0;
        gainQ[e] <= '0;
      end else if (ctl.wrEntry && (wrAddr == IDX_W'(e))) begin
        chanQ[e] <= wrChan;
        gainQ[e] <= wrGain;
      end
    end
  end

  always_comb begin
    lastIdx = IDX_W'(lenReg - LEN_W'(1));
    nextIdx = (ptr == lastIdx) ? '0 : ptr + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= LEN_W'(1);
      ptr     <= '0;
      chanSel <= '0;
      gainSel <= '0;
      cfgErr  <= 1'b0;
    end else begin
      if (ctl.wrLength) lenReg <= wrLen;
      if (ctl.load0) begin
        ptr     <= '0;
        chanSel <= chanQ[0];
        gainSel <= gainQ[0];
      end else if (ctl.advance) begin
        ptr     <= nextIdx;
        chanSel <= chanQ[nextIdx];
        gainSel <= gainQ[nextIdx];
      end
      if (ctl.errSet)      cfgErr <= 1'b1;
      else if (ctl.errClr) cfgErr <= 1'b0;
    end
  end

  assign entryIdx = ptr;

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load0 |=> entryIdx == '0); // R3
  AST_IDX_IN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> entryIdx <= lastIdx); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && entryIdx == lastIdx) |=> entryIdx == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load0 && !ctl.advance) |=> ($stable(chanSel) && $stable(entryIdx))); // R10
  AST_NO_WRITE_IN_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (!ctl.wrEntry && !ctl.wrLength)); // R9
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.errSet |=> cfgErr); // R8
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W = 4,
  parameter int GAIN_W = 2,
  parameter int DIFF_CHANS = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqActive,
  input  logic              convStrobe,
  input  logic              diffMode,
  input  logic              wrEn,
  input  logic              wrIsLen,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [GAIN_W-1:0] wrGain,
  input  logic [LEN_W-1:0]  wrLen,
  output logic [CH_W-1:0]   chanSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic [IDX_W-1:0]  entryIdx,
  output logic              cfgErr
);
  seqStrobe_t strb;

  scan_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W), .DIFF_CHANS(DIFF_CHANS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .acqActive(acqActive), .convStrobe(convStrobe),
    .diffMode(diffMode), .wrEn(wrEn), .wrIsLen(wrIsLen), .wrChan(wrChan),
    .wrLen(wrLen), .strb(strb)
  );

  scan_datapath #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(strb), .wrAddr(wrAddr), .wrChan(wrChan),
    .wrGain(wrGain), .wrLen(wrLen), .chanSel(chanSel), .gainSel(gainSel),
    .entryIdx(entryIdx), .cfgErr(cfgErr)
  );
endmodule

// File: tb/sim_scan_seq_top.sv
module sim_scan_seq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       acqActive = 1'b0, convStrobe = 1'b0, diffMode = 1'b0;
  logic       wrEn = 1'b0, wrIsLen = 1'b0;
  logic [3:0] wrAddr = '0, wrChan = '0;
  logic [1:0] wrGain = '0;
  logic [4:0] wrLen = '0;
  logic [3:0] chanSel, entryIdx;
  logic [1:0] gainSel;
  logic       cfgErr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural reference
  int mqc[16], mqg[16];
  int mlen = 1, mptr = 0, mch = 0, mg = 0, merr = 0;
  bit mscan = 0;

  always #4 clk = ~clk;

  scan_seq_top u0 (
    .clk(clk), .rstN(rstN), .acqActive(acqActive), .convStrobe(convStrobe),
    .diffMode(diffMode), .wrEn(wrEn), .wrIsLen(wrIsLen), .wrAddr(wrAddr),
    .wrChan(wrChan), .wrGain(wrGain), .wrLen(wrLen), .chanSel(chanSel),
    .gainSel(gainSel), .entryIdx(entryIdx), .cfgErr(cfgErr)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin mqc[i] = 0; mqg[i] = 0; end
      mlen = 1; mptr = 0; mch = 0; mg = 0; merr = 0; mscan = 0;
    end else begin
      if (acqActive && !mscan) begin
        mptr = 0; mch = mqc[0]; mg = mqg[0];
      end else if (acqActive && convStrobe) begin
        mptr = (mptr + 1 == mlen) ? 0 : mptr + 1;
        mch = mqc[mptr]; mg = mqg[mptr];
      end
      if (!acqActive && wrEn) begin
        if (wrIsLen) begin
          if (wrLen >= 1 && wrLen <= 16) mlen = int'(wrLen);
        end else if (diffMode && wrChan > 7) begin
          merr = 1;
        end else begin
          mqc[wrAddr] = int'(wrChan); mqg[wrAddr] = int'(wrGain); merr = 0;
        end
      end
      mscan = acqActive;
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 model chanSel", int'(chanSel), mch);
      chk("R2 model gainSel", int'(gainSel), mg);
      chk("R5 model entryIdx", int'(entryIdx), mptr);
      chk("R8 model cfgErr", int'(cfgErr), merr);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrSlot(int a, int ch, int g);
    wrEn = 1; wrIsLen = 0; wrAddr = 4'(a); wrChan = 4'(ch); wrGain = 2'(g);
    tick(); wrEn = 0;
  endtask

  task automatic wrLength(int l);
    wrEn = 1; wrIsLen = 1; wrLen = 5'(l);
    tick(); wrEn = 0; wrIsLen = 0;
  endtask

  task automatic strobe();
    convStrobe = 1; tick(); convStrobe = 0;
  endtask

  task automatic expect3(string tag, int ch, int g, int idx);
    chk({tag, " chan"}, int'(chanSel), ch);
    chk({tag, " gain"}, int'(gainSel), g);
    chk({tag, " idx"}, int'(entryIdx), idx);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rstN = 1; tick();
    expect3("R1 reset", 0, 0, 0);
    chk("R1 reset err", int'(cfgErr), 0);

    wrSlot(0, 3, 0); wrSlot(1, 9, 1); wrSlot(2, 5, 2); wrSlot(3, 12, 3);
    wrLength(4);
    acqActive = 1; tick();
    expect3("R3 start", 3, 0, 0);
    strobe(); expect3("R2 R4 step1", 9, 1, 1);
    tick();   expect3("R4 no strobe hold", 9, 1, 1);
    strobe(); expect3("R4 step2", 5, 2, 2);
    strobe(); expect3("R4 step3", 12, 3, 3);
    strobe(); expect3("R5 wrap", 3, 0, 0);
    strobe(); strobe(); expect3("R4 step2 again", 5, 2, 2);

    // writes during acquisition must be ignored
    wrSlot(0, 7, 2); wrLength(2);
    expect3("R9 outputs", 5, 2, 2);
    acqActive = 0; tick();
    strobe(); strobe();
    expect3("R10 idle strobes", 5, 2, 2);
    acqActive = 1; tick();
    expect3("R9 R11 restart slot0", 3, 0, 0);
    strobe(); strobe(); strobe();
    expect3("R9 length kept", 12, 3, 3);
    strobe(); expect3("R5 wrap len4", 3, 0, 0);

    // out-of-range lengths
    acqActive = 0; tick();
    wrLength(0); wrLength(17);
    acqActive = 1; tick();
    strobe(); strobe(); strobe();
    expect3("R7 len unchanged", 12, 3, 3);
    strobe(); expect3("R7 wrap at 4", 3, 0, 0);

    // single-slot hold
    acqActive = 0; tick();
    wrLength(1);
    acqActive = 1; tick();
    strobe(); expect3("R6 hold a", 3, 0, 0);
    strobe(); strobe(); expect3("R6 hold b", 3, 0, 0);

    // differential mode checks
    acqActive = 0; tick();
    diffMode = 1;
    wrSlot(1, 9, 2);
    chk("R8 refused sets err", int'(cfgErr), 1);
    wrLength(2);
    chk("R8 length keeps err", int'(cfgErr), 1);
    acqActive = 1; tick(); strobe();
    expect3("R8 slot1 unchanged", 9, 1, 1);
    acqActive = 0; tick();
    wrSlot(1, 6, 2);
    chk("R8 accepted clears err", int'(cfgErr), 0);
    diffMode = 0;
    wrSlot(2, 15, 1);
    chk("R8 single-ended high chan", int'(cfgErr), 0);
    wrLength(3);
    acqActive = 1; tick();
    expect3("R11 restart", 3, 0, 0);
    strobe(); expect3("R2 diff slot1", 6, 2, 1);
    strobe(); expect3("R2 slot2", 15, 1, 2);
    strobe(); expect3("R5 wrap len3", 3, 0, 0);
    acqActive = 0; tick(); tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule